// File: doc/BRIEF.md
# Sector Bit-Flip Correction Sequencer

This block finishes the correction of one stored sector once the error positions for that sector are known. On a start pulse it captures the sector configuration and decides whether anything has to be done. If the sector's flag in a per-sector status bitmap is clear, it does nothing. If the number of roots that the root search found differs from the degree of the error-locator polynomial, the sector cannot be corrected. Otherwise it walks the list of error positions and flips one bit for each position.

Each position is one-based and counts bits across the data area followed by the sector's ECC bytes. The sequencer turns a position into a byte index and a bit index. It sends the flip either to the data buffer or to the ECC buffer, and it aborts on a position that lies past both areas. Both buffers are byte-wide RAMs with an asynchronous read port. Every correction is one read-modify-write done in a single cycle.

The block also computes the root-search length for the captured configuration, so that the root finder can be programmed from the same settings. A one-cycle done pulse reports the outcome as a result code and a corrected-error count.

Top module: `sector_fix_seq`

## Requirements
- R1: When the `sectorMap` bit selected by `sectorSel` is clear at start, no buffer is written and the done pulse reports code 0 (OK) with a count of 0.
- R2: When the flag is set and `rootCount` differs from `locDegree`, no buffer is written and done reports code 1 (bad message) with a count of 0.
- R3: Position `pos` is one-based. With p = pos-1, the byte index is p/8 and the bit index is p%8. The addressed byte is rewritten as its read value XOR (1 << bit).
- R4: A byte index below the sector size selects the data buffer at address = byte index.
- R5: A byte index from the sector size up to, but not including, the sector size plus `eccBytes` selects the ECC buffer at address = byte index − sector size.
- R6: A byte index at or beyond the sector size plus `eccBytes` stops correction with code 2 (invalid position) and a count of 0. Position 0 counts as such a position. Nothing is written for that position, and flips already applied stay in place.
- R7: When every position is valid, done reports code 0 with a count equal to `locDegree`. A degree of 0 with the flag set writes nothing and reports count 0.
- R8: Positions are applied in index order 0..degree-1, one per cycle. `done` is a one-cycle pulse. It comes 1 cycle after the start edge for an early exit, degree+1 cycles after it for a full correction, and k+2 cycles after it for an abort at index k.
- R9: From the cycle after start, `searchLen` equals sector_size*8 + m*`strength`, where m is 13 for 512-byte sectors and 14 for 1024-byte sectors.
- R10: `bigSector`=1 selects a 1024-byte sector and `bigSector`=0 selects a 512-byte sector, for both the area split and `searchLen`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| start | input | 1 | Begin one sector; sampled only while idle |
| sectorSel | input | 3 | Index of the sector being corrected |
| sectorMap | input | 8 | Per-sector needs-correction flags |
| bigSector | input | 1 | 1: 1024-byte sector, 0: 512-byte sector |
| eccBytes | input | 6 | ECC bytes stored per sector |
| strength | input | 6 | Correction capability t |
| rootCount | input | 6 | Roots found by the root search |
| locDegree | input | 6 | Degree of the error-locator polynomial |
| posIdx | output | 6 | Index of the position being read |
| posVal | input | 14 | One-based bit position at posIdx |
| dataAddr | output | 10 | Data buffer address |
| dataRdByte | input | 8 | Data buffer read byte (asynchronous) |
| dataWe | output | 1 | Data buffer write enable |
| dataWrByte | output | 8 | Data buffer write byte |
| eccAddr | output | 6 | ECC buffer address |
| eccRdByte | input | 8 | ECC buffer read byte (asynchronous) |
| eccWe | output | 1 | ECC buffer write enable |
| eccWrByte | output | 8 | ECC buffer write byte |
| searchLen | output | 14 | Root-search length for the captured configuration |
| done | output | 1 | One-cycle completion pulse |
| resultCode | output | 2 | 0 OK, 1 bad message, 2 invalid position |
| errCount | output | 6 | Corrected error count |

## Verification
The bench goes after the edges of the area split:
- the last data bit and the first ECC bit, at bit 4096/4097 for small sectors and 8192/8193 for large ones;
- the last valid ECC bit;
- the first bit past the ECC area;
- position 0.

An off-by-one in the decode flips the wrong byte or accepts a position it should reject, and the buffer comparison exposes both. A sequence that hits the same byte twice in a row shows whether each read-modify-write sees the previous write; if it does not, a flip is lost. An abort in the middle of a list must keep the earlier flips and skip the later ones. A cleared status flag, a root-count mismatch and a zero degree must all leave both buffers untouched and still report the right code and latency.

// File: rtl/sector_fix_pkg.sv
package sector_fix_pkg;

  typedef enum logic [1:0] {
    RES_OK     = 2'd0,
    RES_BADMSG = 2'd1,
    RES_BADPOS = 2'd2
  } res_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic latch;      // capture configuration
    logic fix;        // apply current position
    logic step;       // advance position index
    logic finish;     // raise done and record result
    res_e code;       // result to record
    logic keepCount;  // record degree as count
  } strobe_t;

endpackage

// File: rtl/sector_fix_ctrl.sv
module sector_fix_ctrl
  import sector_fix_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    statusHit,
  input  logic    rootsMatch,
  input  logic    degZero,
  input  logic    lastIdx,
  input  logic    posBad,
  output strobe_t strb
);

  typedef enum logic [1:0] {ST_IDLE, ST_CHECK, ST_FIX} state_e;

  state_e state, nxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    strb = '0;
    nxt  = state;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strb.latch = 1'b1;
          nxt        = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (!statusHit) begin
          strb.finish = 1'b1;
          strb.code   = RES_OK;
          nxt         = ST_IDLE;
        end else if (!rootsMatch) begin
          strb.finish = 1'b1;
          strb.code   = RES_BADMSG;
          nxt         = ST_IDLE;
        end else if (degZero) begin
          strb.finish = 1'b1;
          strb.code   = RES_OK;
          nxt         = ST_IDLE;
        end else begin
          nxt = ST_FIX;
        end
      end
      ST_FIX: begin
        strb.fix = 1'b1;
        if (posBad) begin
          strb.finish = 1'b1;
          strb.code   = RES_BADPOS;
          nxt         = ST_IDLE;
        end else if (lastIdx) begin
          strb.finish    = 1'b1;
          strb.code      = RES_OK;
          strb.keepCount = 1'b1;
          nxt            = ST_IDLE;
        end else begin
          strb.step = 1'b1;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  // R2 / R1: corrections only run on a flagged sector with matching roots
  assert_fix_gated_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FIX) |-> (statusHit && rootsMatch));

  // R8: a correction run never starts with zero positions
  assert_fix_nonzero_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FIX) |-> !degZero);

endmodule

// File: rtl/sector_fix_dp.sv
module sector_fix_dp
  import sector_fix_pkg::*;
#(
  parameter int NUM_SECTORS = 8,
  parameter int MAX_T       = 32,
  parameter int POS_W       = 14,
  parameter int SMALL_BYTES = 512,
  parameter int BIG_BYTES   = 1024,
  parameter int GF_SMALL    = 13,
  parameter int GF_BIG      = 14,
  parameter int ECC_MAX     = 63,
  localparam int SECT_W  = $clog2(NUM_SECTORS),
  localparam int DEG_W   = $clog2(MAX_T + 1),
  localparam int DATA_AW = $clog2(BIG_BYTES),
  localparam int ECC_AW  = $clog2(ECC_MAX + 1),
  localparam int BYTE_W  = POS_W - 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strb,
  input  logic [SECT_W-1:0]  sectorSel,
  input  logic [NUM_SECTORS-1:0] sectorMap,
  input  logic               bigSector,
  input  logic [ECC_AW-1:0]  eccBytes,
  input  logic [DEG_W-1:0]   strength,
  input  logic [DEG_W-1:0]   rootCount,
  input  logic [DEG_W-1:0]   locDegree,
  output logic [DEG_W-1:0]   posIdx,
  input  logic [POS_W-1:0]   posVal,
  output logic [DATA_AW-1:0] dataAddr,
  input  logic [7:0]         dataRdByte,
  output logic               dataWe,
  output logic [7:0]         dataWrByte,
  output logic [ECC_AW-1:0]  eccAddr,
  input  logic [7:0]         eccRdByte,
  output logic               eccWe,
  output logic [7:0]         eccWrByte,
  output logic [POS_W-1:0]   searchLen,
  output logic               done,
  output logic [1:0]         resultCode,
  output logic [DEG_W-1:0]   errCount,
  output logic               statusHit,
  output logic               rootsMatch,
  output logic               degZero,
  output logic               lastIdx,
  output logic               posBad
);

  localparam logic [BYTE_W-1:0] SMALL_B = BYTE_W'(SMALL_BYTES);
  localparam logic [BYTE_W-1:0] BIG_B   = BYTE_W'(BIG_BYTES);

  logic              statusHitQ, bigQ, doneQ, keepQ;
  logic [DEG_W-1:0]  rootsQ, degQ, idxQ, countQ;
  logic [ECC_AW-1:0] eccQ;
  logic [POS_W-1:0]  searchLenQ;
  res_e              codeQ;

  // Captured configuration and result registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusHitQ <= 1'b0;
      bigQ       <= 1'b0;
      rootsQ     <= '0;
      degQ       <= '0;
      eccQ       <= '0;
      searchLenQ <= '0;
      idxQ       <= '0;
      doneQ      <= 1'b0;
      keepQ      <= 1'b0;
      codeQ      <= RES_OK;
      countQ     <= '0;
    end else begin
      doneQ <= strb.finish;
      if (strb.latch) begin
        statusHitQ <= sectorMap[sectorSel];
        bigQ       <= bigSector;
        rootsQ     <= rootCount;
        degQ       <= locDegree;
        eccQ       <= eccBytes;
        idxQ       <= '0;
        if (bigSector)
          searchLenQ <= POS_W'(BIG_BYTES * 8) + POS_W'(GF_BIG * int'(strength));
        else
          searchLenQ <= POS_W'(SMALL_BYTES * 8) + POS_W'(GF_SMALL * int'(strength));
      end else if (strb.step) begin
        idxQ <= idxQ + DEG_W'(1);
      end
      if (strb.finish) begin
        codeQ  <= strb.code;
        keepQ  <= strb.keepCount;
        countQ <= strb.keepCount ? degQ : '0;
      end
    end
  end

  // Position decode
  logic [POS_W-1:0]  posM1;
  logic [BYTE_W-1:0] byteIdx, secBytes, areaEnd, eccOff;
  logic [2:0]        bitIdx;
  logic [7:0]        flipMask;
  logic              inData, inEcc;

  always_comb begin
    posM1    = posVal - POS_W'(1);
    byteIdx  = posM1[POS_W-1:3];
    bitIdx   = posM1[2:0];
    secBytes = bigQ ? BIG_B : SMALL_B;
    areaEnd  = secBytes + BYTE_W'(eccQ);
    inData   = byteIdx < secBytes;
    inEcc    = !inData && (byteIdx < areaEnd);
    eccOff   = byteIdx - secBytes;
    flipMask = 8'b1 << bitIdx;
  end

  assign posIdx     = idxQ;
  assign dataAddr   = byteIdx[DATA_AW-1:0];
  assign eccAddr    = eccOff[ECC_AW-1:0];
  assign dataWe     = strb.fix && inData;
  assign eccWe      = strb.fix && inEcc;
  assign dataWrByte = dataRdByte ^ flipMask;
  assign eccWrByte  = eccRdByte ^ flipMask;

  assign searchLen  = searchLenQ;
  assign done       = doneQ;
  assign resultCode = codeQ;
  assign errCount   = countQ;

  assign statusHit  = statusHitQ;
  assign rootsMatch = (rootsQ == degQ);
  assign degZero    = (degQ == '0);
  assign lastIdx    = (idxQ == degQ - DEG_W'(1));
  assign posBad     = !inData && !inEcc;

  // R1: unflagged sector finishes clean
  assert_skip_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    (doneQ && !statusHitQ) |-> (countQ == '0 && codeQ == RES_OK));

  // R2: root mismatch reports bad message
  assert_badmsg_R2: assert property (@(posedge clk) disable iff (!rstN)
    (doneQ && statusHitQ && rootsQ != degQ) |-> (codeQ == RES_BADMSG));

  // R3: each write changes exactly one bit of the byte read
  assert_one_bit_data_R3: assert property (@(posedge clk) disable iff (!rstN)
    dataWe |-> ($countones(dataWrByte ^ dataRdByte) == 1));
  assert_one_bit_ecc_R3: assert property (@(posedge clk) disable iff (!rstN)
    eccWe |-> ($countones(eccWrByte ^ eccRdByte) == 1));

  // R5: ECC address stays inside the captured ECC area
  assert_ecc_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    eccWe |-> (eccAddr < eccQ));

  // R7: successful completion reports the degree
  assert_count_R7: assert property (@(posedge clk) disable iff (!rstN)
    (doneQ && keepQ) |-> (countQ == degQ && codeQ == RES_OK));

  // R8: done is a single-cycle pulse
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ);

endmodule

// File: rtl/sector_fix_seq.sv
module sector_fix_seq
  import sector_fix_pkg::*;
#(
  parameter int NUM_SECTORS = 8,
  parameter int MAX_T       = 32,
  parameter int POS_W       = 14,
  parameter int SMALL_BYTES = 512,
  parameter int BIG_BYTES   = 1024,
  parameter int GF_SMALL    = 13,
  parameter int GF_BIG      = 14,
  parameter int ECC_MAX     = 63,
  localparam int SECT_W  = $clog2(NUM_SECTORS),
  localparam int DEG_W   = $clog2(MAX_T + 1),
  localparam int DATA_AW = $clog2(BIG_BYTES),
  localparam int ECC_AW  = $clog2(ECC_MAX + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   start,
  input  logic [SECT_W-1:0]      sectorSel,
  input  logic [NUM_SECTORS-1:0] sectorMap,
  input  logic                   bigSector,
  input  logic [ECC_AW-1:0]      eccBytes,
  input  logic [DEG_W-1:0]       strength,
  input  logic [DEG_W-1:0]       rootCount,
  input  logic [DEG_W-1:0]       locDegree,
  output logic [DEG_W-1:0]       posIdx,
  input  logic [POS_W-1:0]       posVal,
  output logic [DATA_AW-1:0]     dataAddr,
  input  logic [7:0]             dataRdByte,
  output logic                   dataWe,
  output logic [7:0]             dataWrByte,
  output logic [ECC_AW-1:0]      eccAddr,
  input  logic [7:0]             eccRdByte,
  output logic                   eccWe,
  output logic [7:0]             eccWrByte,
  output logic [POS_W-1:0]       searchLen,
  output logic                   done,
  output logic [1:0]             resultCode,
  output logic [DEG_W-1:0]       errCount
);

  strobe_t strb;
  logic statusHit, rootsMatch, degZero, lastIdx, posBad;

  sector_fix_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .statusHit  (statusHit),
    .rootsMatch (rootsMatch),
    .degZero    (degZero),
    .lastIdx    (lastIdx),
    .posBad     (posBad),
    .strb       (strb)
  );

  sector_fix_dp #(
    .NUM_SECTORS (NUM_SECTORS),
    .MAX_T       (MAX_T),
    .POS_W       (POS_W),
    .SMALL_BYTES (SMALL_BYTES),
    .BIG_BYTES   (BIG_BYTES),
    .GF_SMALL    (GF_SMALL),
    .GF_BIG      (GF_BIG),
    .ECC_MAX     (ECC_MAX)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .sectorSel  (sectorSel),
    .sectorMap  (sectorMap),
    .bigSector  (bigSector),
    .eccBytes   (eccBytes),
    .strength   (strength),
    .rootCount  (rootCount),
    .locDegree  (locDegree),
    .posIdx     (posIdx),
    .posVal     (posVal),
    .dataAddr   (dataAddr),
    .dataRdByte (dataRdByte),
    .dataWe     (dataWe),
    .dataWrByte (dataWrByte),
    .eccAddr    (eccAddr),
    .eccRdByte  (eccRdByte),
    .eccWe      (eccWe),
    .eccWrByte  (eccWrByte),
    .searchLen  (searchLen),
    .done       (done),
    .resultCode (resultCode),
    .errCount   (errCount),
    .statusHit  (statusHit),
    .rootsMatch (rootsMatch),
    .degZero    (degZero),
    .lastIdx    (lastIdx),
    .posBad     (posBad)
  );

endmodule

// File: tb/sector_fix_seq_tb.sv
`timescale 1ns/1ps
module sector_fix_seq_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  sectorSel = '0;
  logic [7:0]  sectorMap = '0;
  logic        bigSector = 1'b0;
  logic [5:0]  eccBytes = '0, strength = '0, rootCount = '0, locDegree = '0;
  logic [5:0]  posIdx;
  logic [13:0] posVal;
  logic [9:0]  dataAddr;
  logic [7:0]  dataRdByte, dataWrByte, eccRdByte, eccWrByte;
  logic        dataWe, eccWe, done;
  logic [5:0]  eccAddr, errCount;
  logic [13:0] searchLen;
  logic [1:0]  resultCode;

  always #2.5 clk = ~clk;

  logic [7:0]  dataMem [1024];
  logic [7:0]  eccMem  [64];
  logic [7:0]  refData [1024];
  logic [7:0]  refEcc  [64];
  logic [13:0] posTab  [32];

  assign dataRdByte = dataMem[dataAddr];
  assign eccRdByte  = eccMem[eccAddr];
  assign posVal     = posTab[posIdx[4:0]];

  always @(posedge clk) begin
    if (dataWe) dataMem[dataAddr] <= dataWrByte;
    if (eccWe)  eccMem[eccAddr]   <= eccWrByte;
  end

  sector_fix_seq u_dut (
    .clk(clk), .rstN(rstN), .start(start), .sectorSel(sectorSel),
    .sectorMap(sectorMap), .bigSector(bigSector), .eccBytes(eccBytes),
    .strength(strength), .rootCount(rootCount), .locDegree(locDegree),
    .posIdx(posIdx), .posVal(posVal), .dataAddr(dataAddr),
    .dataRdByte(dataRdByte), .dataWe(dataWe), .dataWrByte(dataWrByte),
    .eccAddr(eccAddr), .eccRdByte(eccRdByte), .eccWe(eccWe),
    .eccWrByte(eccWrByte), .searchLen(searchLen), .done(done),
    .resultCode(resultCode), .errCount(errCount)
  );

  typedef struct packed {
    logic        big;
    logic [2:0]  sect;
    logic [7:0]  map;
    logic [5:0]  roots;
    logic [5:0]  deg;
    logic [5:0]  ecc;
    logic [5:0]  t;
    logic [13:0] p0;
    logic [13:0] p1;
    logic [13:0] p2;
    logic [1:0]  code;
    logic [5:0]  cnt;
    logic [5:0]  lat;
  } vec_t;

  // big, sect, map, roots, deg, ecc, t, p0, p1, p2, code, cnt, lat
  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 3'd2, 8'h04, 6'd2, 6'd2, 6'd13, 6'd4,  14'd1,    14'd4100, 14'd0,    2'd0, 6'd2, 6'd3}, // R3 R4 R5
    '{1'b0, 3'd3, 8'hF7, 6'd1, 6'd1, 6'd13, 6'd4,  14'd10,   14'd0,    14'd0,    2'd0, 6'd0, 6'd1}, // R1
    '{1'b0, 3'd0, 8'h01, 6'd2, 6'd3, 6'd13, 6'd4,  14'd3,    14'd4,    14'd5,    2'd1, 6'd0, 6'd1}, // R2
    '{1'b1, 3'd5, 8'h20, 6'd3, 6'd3, 6'd56, 6'd32, 14'd8192, 14'd8193, 14'd8640, 2'd0, 6'd3, 6'd4}, // R10 R5
    '{1'b0, 3'd1, 8'h02, 6'd3, 6'd3, 6'd13, 6'd4,  14'd5,    14'd4201, 14'd7,    2'd2, 6'd0, 6'd3}, // R6 mid abort
    '{1'b0, 3'd7, 8'h80, 6'd1, 6'd1, 6'd13, 6'd4,  14'd0,    14'd0,    14'd0,    2'd2, 6'd0, 6'd2}, // R6 pos 0
    '{1'b0, 3'd4, 8'h10, 6'd0, 6'd0, 6'd13, 6'd4,  14'd0,    14'd0,    14'd0,    2'd0, 6'd0, 6'd1}, // R7 deg 0
    '{1'b1, 3'd6, 8'h40, 6'd3, 6'd3, 6'd20, 6'd8,  14'd9,    14'd10,   14'd9,    2'd0, 6'd3, 6'd4}, // R3 same byte
    '{1'b0, 3'd2, 8'h04, 6'd2, 6'd2, 6'd13, 6'd4,  14'd4096, 14'd4097, 14'd0,    2'd0, 6'd2, 6'd3}, // R4 R5 edge
    '{1'b1, 3'd0, 8'h01, 6'd1, 6'd1, 6'd56, 6'd32, 14'd8641, 14'd0,    14'd0,    2'd2, 6'd0, 6'd2}  // R6 big edge
  };

  int nChecks = 0;
  int nFails  = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic ref_apply(input vec_t v);
    logic [13:0] pt [3];
    int ss;
    pt[0] = v.p0; pt[1] = v.p1; pt[2] = v.p2;
    ss = v.big ? 1024 : 512;
    if (v.map[v.sect] && v.roots == v.deg) begin
      for (int i = 0; i < int'(v.deg); i++) begin
        int p, by, bt;
        if (pt[i] == 0) break;
        p  = int'(pt[i]) - 1;
        by = p / 8;
        bt = p % 8;
        if (by < ss) refData[by] ^= 8'(1 << bt);
        else if (by < ss + int'(v.ecc)) refEcc[by - ss] ^= 8'(1 << bt);
        else break;
      end
    end
  endtask

  task automatic run_vec(input vec_t v, input int num);
    int lat, expLen, mism;
    for (int i = 0; i < 32; i++) posTab[i] = 14'd0;
    posTab[0] = v.p0; posTab[1] = v.p1; posTab[2] = v.p2;
    ref_apply(v);
    @(posedge clk); #1;
    sectorSel = v.sect; sectorMap = v.map; bigSector = v.big;
    eccBytes = v.ecc; strength = v.t; rootCount = v.roots; locDegree = v.deg;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    expLen = (v.big ? 8192 : 4096) + (v.big ? 14 : 13) * int'(v.t);
    chk(int'(searchLen) == expLen, $sformatf("R9 R10 searchLen vec %0d", num), int'(searchLen), expLen);
    lat = 0;
    while (lat < 100) begin
      @(posedge clk); #1;
      lat++;
      if (done) break;
    end
    chk(lat == int'(v.lat), $sformatf("R8 done latency vec %0d", num), lat, int'(v.lat));
    chk(resultCode == v.code, $sformatf("R1 R2 R6 R7 code vec %0d", num), int'(resultCode), int'(v.code));
    chk(errCount == v.cnt, $sformatf("R7 count vec %0d", num), int'(errCount), int'(v.cnt));
    @(posedge clk); #1;
    chk(done == 1'b0, $sformatf("R8 pulse width vec %0d", num), int'(done), 0);
    mism = 0;
    for (int i = 0; i < 1024; i++) if (dataMem[i] !== refData[i]) mism++;
    chk(mism == 0, $sformatf("R3 R4 data buffer vec %0d", num), mism, 0);
    mism = 0;
    for (int i = 0; i < 64; i++) if (eccMem[i] !== refEcc[i]) mism++;
    chk(mism == 0, $sformatf("R3 R5 ecc buffer vec %0d", num), mism, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) begin
      dataMem[i] = 8'((i * 37) ^ 8'h5A);
      refData[i] = 8'((i * 37) ^ 8'h5A);
    end
    for (int i = 0; i < 64; i++) begin
      eccMem[i] = 8'((i * 11) ^ 8'hC3);
      refEcc[i] = 8'((i * 11) ^ 8'hC3);
    end
    for (int i = 0; i < 32; i++) posTab[i] = 14'd0;
    repeat (3) @(posedge clk);
    #1;
    // R8: reset state
    chk(done == 1'b0, "R8 reset done", int'(done), 0);
    chk(resultCode == 2'd0, "R7 reset code", int'(resultCode), 0);
    chk(errCount == 6'd0, "R7 reset count", int'(errCount), 0);
    rstN = 1'b1;
    @(posedge clk); #1;
    chk(!dataWe && !eccWe, "R1 idle no write", int'({dataWe, eccWe}), 0);

    for (int v = 0; v < NV; v++) run_vec(VECS[v], v);

    // R6: abort leaves later positions unapplied, rerun with same data
    run_vec(VECS[4], 100);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule